// File: doc/BRIEF.md
# Relative-Addressed Register Move Unit

This block executes single-source move instructions, each a 64-bit word, against a small register file that it holds itself. It decodes where the value comes from. The source can be a 32-bit immediate, an entry of an external constant memory, or a register. The register and constant forms may also be reached through a live 16-bit address register plus an offset. The destination can be a fixed register index, or the address register plus an unsigned offset. One special encoding sends the moved value into the address register instead of the register file. A repeat field makes the unit perform the move up to four times, walking through consecutive registers.

Each iteration takes one clock and shows up on the write outputs, which mirror every update of the internal register file. Values are sign- or zero-extended from 16 to 32 bits, or narrowed to 16 bits, according to 3-bit source and destination type codes.

Words enter on a valid/ready port. `in_ready` is high only while the unit is idle, including the cycle of the done pulse. A word transfers on the clock edge at which `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the sender must hold the word steady. A word that fails the class check is still consumed, and it has no effect. The constant memory is read combinationally: `cst_data` must answer `cst_addr` within the same cycle.

Top module: `rmu_top`

## Requirements
- R1: A word is executed only if bits 63:61 are 001, bit 42 is 0, bits 58:57 are 00 and bits 54:53 are not 11. Any other word is consumed with no register write, no address register change and no done pulse.
- R2: `in_ready` is high exactly when no move is in progress. A word presented while busy is not taken.
- R3: Source kind 10 (bits 54:53) uses bits 31:0 of the word as the source value.
- R4: Source kind 01 drives bits 10:0 of the word onto `cst_addr` and uses `cst_data` as the source value.
- R5: Source kind 00 with bit 11 clear reads the register whose index is bits 7:0, taken modulo the register count.
- R6: Source kind 00 with bit 11 set is relative, and its index is the address register plus bits 9:0. Bit 10 clear reads that register (modulo the register count); bit 10 set reads the constant at the low 11 bits of that sum.
- R7: The destination index is bits 39:32. When bit 49 is set, it is the address register plus that field as an unsigned value. Either index is taken modulo the register count.
- R8: When the destination field is 0xF4 and both type codes are 4, the low 16 bits of the value go to the address register and no register-file write happens. Field 0xF4 with any other types writes register 0xF4 modulo the register count.
- R9: Bits 41:40 hold a count N. The unit writes on N+1 consecutive cycles, with the destination index advancing by one each time. Register and relative sources also advance by one each time; immediate and plain constant sources stay fixed. Each read sees the writes of the earlier iterations.
- R10: The source type is bits 52:50 and the destination type is bits 48:46. Codes 0, 2, 4, 6 and 7 are 16-bit types, and codes 4 and 7 are signed. A 16-bit source moved to a 32-bit destination is sign-extended from bit 15 for a signed source and zero-extended otherwise.
- R11: A 16-bit destination receives the low 16 bits of the value, with bits 31:16 of the written word zero.
- R12: `done` pulses for one cycle, in the cycle after the last iteration, and `in_ready` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is offered |
| in_ready | output | 1 | Unit is idle and takes a word |
| in_word | input | 64 | Instruction word |
| cst_addr | output | 11 | Constant memory read index |
| cst_data | input | 32 | Constant memory read value, same cycle |
| wr_en | output | 1 | Register-file write this cycle |
| wr_idx | output | $clog2(REGS) | Register index written |
| wr_data | output | 32 | Value written |
| areg | output | 16 | Address register |
| done | output | 1 | One-cycle pulse after the last iteration |

## Verification
The assertions check several rules on every cycle. A 16-bit destination never receives upper bits. A widened signed value carries its sign. The address register changes only after an iteration aimed at it. The iteration counter stays within the repeat count. `done` follows a busy cycle and falls in an idle one. Only the bench's scenarios can show that the right source is chosen for each kind and offset, and that indices wrap modulo the register count. They also show that overlapping repeated copies propagate through earlier writes, and that rejected words leave no trace. The bench covers these by sweeping all 64 type-code pairs and filling every register.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  localparam int AREG_W = 16;
  localparam int DATA_W = 32;
  localparam logic [7:0] AREG_SLOT = 8'hF4;
  localparam logic [2:0] TY_S16 = 3'd4;

  typedef enum logic [1:0] {
    SK_REG = 2'b00,
    SK_CST = 2'b01,
    SK_IMM = 2'b10,
    SK_BAD = 2'b11
  } src_kind_e;

  typedef struct packed {
    logic        legal;
    src_kind_e   kind;
    logic        rel;
    logic        rel_cst;
    logic [9:0]  off;
    logic [31:0] imm;
    logic [7:0]  dst;
    logic        dst_rel;
    logic [1:0]  rpt;
    logic [2:0]  st;
    logic [2:0]  dt;
    logic        to_areg;
  } mv_op_t;

  function automatic logic ty_half(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd2) || (c == 3'd4) || (c == 3'd6) || (c == 3'd7);
  endfunction

  function automatic logic ty_signed(input logic [2:0] c);
    return (c == 3'd4) || (c == 3'd7);
  endfunction
endpackage

// File: rtl/rmu_decode.sv
module rmu_decode
  import rmu_pkg::*;
(
  input  logic [63:0] word,
  output mv_op_t      op
);
  logic unused_bits;
  assign unused_bits = ^{word[60:59], word[56:55], word[45:43]};

  always_comb begin
    // R1 class filter
    op.legal   = (word[63:61] == 3'b001) && !word[42] && (word[58:57] == 2'b00)
               && (word[54:53] != 2'b11);
    op.kind    = src_kind_e'(word[54:53]);
    op.rel     = (word[54:53] == 2'b00) && word[11];
    op.rel_cst = word[10];
    op.off     = word[9:0];
    op.imm     = word[31:0];
    op.dst     = word[39:32];
    op.dst_rel = word[49];
    op.rpt     = word[41:40];
    op.st      = word[52:50];
    op.dt      = word[48:46];
    op.to_areg = (word[39:32] == AREG_SLOT) && (word[52:50] == TY_S16)
               && (word[48:46] == TY_S16);
  end
endmodule

// File: rtl/rmu_seq.sv
module rmu_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] rpt,
  output logic       busy,
  output logic [1:0] iter,
  output logic       done
);
  logic last;
  assign last = busy && (iter == rpt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      iter <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        busy <= 1'b1;
        iter <= '0;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        iter <= iter + 2'd1;
      end
    end
  end

  assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_iter_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter <= rpt));
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/rmu_fetch.sv
module rmu_fetch
  import rmu_pkg::*;
#(
  parameter int REGS = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      active,
  input  mv_op_t                    op,
  input  logic [1:0]                iter,
  input  logic [AREG_W-1:0]         areg,
  output logic [$clog2(REGS)-1:0]   rf_idx,
  input  logic [DATA_W-1:0]         rf_data,
  output logic [10:0]               cst_addr,
  input  logic [DATA_W-1:0]         cst_data,
  output logic [DATA_W-1:0]         data
);
  localparam int IDX_W = $clog2(REGS);

  logic [AREG_W-1:0] rel_sum, plain_sum;
  logic [DATA_W-1:0] raw;
  logic unused_fetch;

  assign rel_sum   = areg + AREG_W'(op.off) + AREG_W'(iter);
  assign plain_sum = AREG_W'(op.off[7:0]) + AREG_W'(iter);
  assign rf_idx    = op.rel ? rel_sum[IDX_W-1:0] : plain_sum[IDX_W-1:0];
  assign cst_addr  = op.rel ? rel_sum[10:0] : op.imm[10:0];
  assign unused_fetch = ^{op.legal, op.dst, op.dst_rel, op.rpt, op.to_areg,
                          rel_sum[AREG_W-1:11], plain_sum};

  always_comb begin
    case (op.kind)
      SK_IMM:  raw = op.imm;
      SK_CST:  raw = cst_data;
      default: raw = (op.rel && op.rel_cst) ? cst_data : rf_data;
    endcase
    if (ty_half(op.st))
      data = ty_signed(op.st) ? {{16{raw[15]}}, raw[15:0]} : {16'd0, raw[15:0]};
    else
      data = raw;
    if (ty_half(op.dt))
      data = {16'd0, data[15:0]};
  end

  assert_sign_widen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ty_half(op.st) && ty_signed(op.st) && !ty_half(op.dt))
      |-> (data[31:16] == {16{data[15]}}));
endmodule

// File: rtl/rmu_top.sv
module rmu_top
  import rmu_pkg::*;
#(
  parameter int REGS = 64,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [63:0]        in_word,
  output logic [10:0]        cst_addr,
  input  logic [31:0]        cst_data,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [31:0]        wr_data,
  output logic [15:0]        areg,
  output logic               done
);
  mv_op_t dec, op_q;
  logic busy, start;
  logic [1:0] iter;
  logic [DATA_W-1:0] rf [REGS];
  logic [IDX_W-1:0] rd_idx;
  logic [DATA_W-1:0] src_val;
  logic [AREG_W-1:0] dsum;
  logic unused_top;

  rmu_decode u_dec (.word(in_word), .op(dec));

  assign in_ready = !busy;
  assign start    = in_valid && in_ready && dec.legal;

  always_ff @(posedge clk) begin
    if (!rst_n) op_q <= '0;
    else if (start) op_q <= dec;
  end

  rmu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rpt(op_q.rpt),
    .busy(busy), .iter(iter), .done(done)
  );

  rmu_fetch #(.REGS(REGS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .active(busy), .op(op_q), .iter(iter), .areg(areg),
    .rf_idx(rd_idx), .rf_data(rf[rd_idx]), .cst_addr(cst_addr),
    .cst_data(cst_data), .data(src_val)
  );

  assign dsum    = (op_q.dst_rel ? areg : '0) + AREG_W'(op_q.dst) + AREG_W'(iter);
  assign wr_idx  = dsum[IDX_W-1:0];
  assign wr_en   = busy && !op_q.to_areg;
  assign wr_data = src_val;
  assign unused_top = ^{op_q.legal, dsum[AREG_W-1:IDX_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) areg <= '0;
    else if (busy && op_q.to_areg) areg <= src_val[15:0];
  end

  assert_half_dst_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ty_half(op_q.dt)) |-> (wr_data[31:16] == 16'd0));
  assert_areg_only_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(areg) |-> $past(busy && op_q.to_areg));
  assert_no_write_when_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !in_ready);
endmodule

// File: tb/tb_rmu_top.sv
`timescale 1ns/1ps
module tb_rmu_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [63:0] in_word = '0;
  logic [10:0] cst_addr;
  logic [31:0] cst_data;
  logic wr_en;
  logic [5:0] wr_idx;
  logic [31:0] wr_data;
  logic [15:0] areg;
  logic done;

  int checks = 0;
  int errors = 0;
  logic [31:0] mregs [64];
  logic [15:0] ma0 = '0;

  always #2.5 clk = ~clk;

  rmu_top #(.REGS(64)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .cst_addr(cst_addr), .cst_data(cst_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .areg(areg), .done(done)
  );

  function automatic logic [31:0] cval(input logic [10:0] a);
    return 32'h5A00_0000 ^ ({21'd0, a} * 32'd40503);
  endfunction
  assign cst_data = cval(cst_addr);

  function automatic logic is_h(input logic [2:0] c);
    return (c == 0) || (c == 2) || (c == 4) || (c == 6) || (c == 7);
  endfunction

  function automatic logic [31:0] conv(input logic [31:0] raw, input logic [2:0] st, input logic [2:0] dt);
    logic [31:0] v;
    v = raw;
    if (is_h(st)) v = ((st == 4 || st == 7) && raw[15]) ? {16'hFFFF, raw[15:0]} : {16'h0, raw[15:0]};
    if (is_h(dt)) v = {16'h0, v[15:0]};
    return v;
  endfunction

  function automatic logic [63:0] mk(input logic [1:0] kind, input logic [31:0] s, input logic [7:0] d,
                                     input logic drel, input logic [1:0] rpt, input logic [2:0] st,
                                     input logic [2:0] dt);
    logic [63:0] w;
    w = '0;
    w[63:61] = 3'b001; w[54:53] = kind; w[52:50] = st; w[49] = drel;
    w[48:46] = dt; w[41:40] = rpt; w[39:32] = d; w[31:0] = s;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] w, input string tag);
    int n;
    logic mova;
    n = int'(w[41:40]) + 1;
    mova = (w[39:32] == 8'hF4) && (w[52:50] == 3'd4) && (w[48:46] == 3'd4);
    @(negedge clk);
    in_word = w; in_valid = 1'b1;
    chk("R2 ready idle", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [15:0] s, d;
      logic [31:0] raw, e;
      logic [5:0] eidx;
      case (w[54:53])
        2'b10: raw = w[31:0];
        2'b01: raw = cval(w[10:0]);
        default: begin
          if (w[11]) begin
            s = ma0 + 16'(w[9:0]) + 16'(i);
            raw = w[10] ? cval(s[10:0]) : mregs[s[5:0]];
          end else begin
            s = 16'(w[7:0]) + 16'(i);
            raw = mregs[s[5:0]];
          end
        end
      endcase
      e = conv(raw, w[52:50], w[48:46]);
      d = (w[49] ? ma0 : 16'd0) + 16'(w[39:32]) + 16'(i);
      eidx = d[5:0];
      chk("R2 busy not ready", {31'd0, in_ready}, 32'd0);
      if (mova) begin
        chk("R8 no rf write", {31'd0, wr_en}, 32'd0);
        ma0 = e[15:0];
      end else begin
        chk("R9 write each cycle", {31'd0, wr_en}, 32'd1);
        chk("R7 dest index", {26'd0, wr_idx}, {26'd0, eidx});
        chk(tag, wr_data, e);
        mregs[eidx] = e;
      end
      @(negedge clk);
    end
    chk("R12 done", {31'd0, done}, 32'd1);
    chk("R12 ready on done", {31'd0, in_ready}, 32'd1);
    chk("R8 areg", {16'd0, areg}, {16'd0, ma0});
  endtask

  task automatic reject(input logic [63:0] w);
    @(negedge clk);
    in_word = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) begin
      chk("R1 no write", {31'd0, wr_en}, 32'd0);
      chk("R1 no done", {31'd0, done}, 32'd0);
      chk("R1 still ready", {31'd0, in_ready}, 32'd1);
      chk("R1 areg kept", {16'd0, areg}, {16'd0, ma0});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mregs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset ready", {31'd0, in_ready}, 32'd1);
    chk("R12 reset done", {31'd0, done}, 32'd0);
    chk("R9 reset wr_en", {31'd0, wr_en}, 32'd0);
    chk("R8 reset areg", {16'd0, areg}, 32'd0);

    // R3: fill every register from immediates
    for (int i = 0; i < 64; i++)
      run(mk(2'b10, 32'h9E37_79B9 * (i + 1), 8'(i), 1'b0, 2'd0, 3'd3, 3'd3), "R3 immediate");

    // R10 / R11: sweep all type pairs
    for (int st = 0; st < 8; st++)
      for (int dt = 0; dt < 8; dt++) begin
        run(mk(2'b10, 32'h8765_F0A3, 8'd10, 1'b0, 2'd0, 3'(st), 3'(dt)), "R10 R11 types neg");
        run(mk(2'b10, 32'h1234_7F5C, 8'd11, 1'b0, 2'd0, 3'(st), 3'(dt)), "R10 R11 types pos");
        run(mk(2'b00, 32'd10, 8'd12, 1'b0, 2'd0, 3'(st), 3'(dt)), "R10 R11 reg types");
      end

    // R4: constant sources
    run(mk(2'b01, 32'd0, 8'd20, 1'b0, 2'd0, 3'd3, 3'd3), "R4 const 0");
    run(mk(2'b01, 32'd2047, 8'd21, 1'b0, 2'd0, 3'd3, 3'd3), "R4 const top");
    run(mk(2'b01, 32'd1234, 8'd22, 1'b0, 2'd0, 3'd5, 3'd5), "R4 const");

    // R5: register sources, index modulo 64
    run(mk(2'b00, 32'd3, 8'd40, 1'b0, 2'd0, 3'd3, 3'd3), "R5 reg copy");
    run(mk(2'b00, 32'h47, 8'd41, 1'b0, 2'd0, 3'd3, 3'd3), "R5 reg wrap");

    // R8: address register load, and near miss
    run(mk(2'b10, 32'h0000_0005, 8'hF4, 1'b0, 2'd0, 3'd4, 3'd4), "R8 load areg");
    run(mk(2'b10, 32'hCAFE_0001, 8'hF4, 1'b0, 2'd0, 3'd3, 3'd3), "R8 near miss");

    // R6: relative sources
    run(mk(2'b00, 32'h800 | 32'd10, 8'd42, 1'b0, 2'd0, 3'd3, 3'd3), "R6 rel reg");
    run(mk(2'b00, 32'hC00 | 32'd100, 8'd43, 1'b0, 2'd0, 3'd3, 3'd3), "R6 rel const");

    // R7: relative destination
    run(mk(2'b10, 32'hDEAD_BEEF, 8'd3, 1'b1, 2'd0, 3'd3, 3'd3), "R7 rel dst");
    run(mk(2'b10, 32'd62, 8'hF4, 1'b0, 2'd0, 3'd4, 3'd4), "R8 load 62");
    run(mk(2'b10, 32'h0BAD_F00D, 8'd5, 1'b1, 2'd0, 3'd3, 3'd3), "R7 rel dst wrap");
    run(mk(2'b10, 32'h0000_FFFE, 8'hF4, 1'b0, 2'd0, 3'd4, 3'd4), "R8 load negative");
    run(mk(2'b00, 32'h800 | 32'd4, 8'd44, 1'b0, 2'd0, 3'd3, 3'd3), "R6 rel reg neg areg");

    // R9: repeats
    run(mk(2'b00, 32'd0, 8'd30, 1'b0, 2'd3, 3'd3, 3'd3), "R9 reg repeat");
    run(mk(2'b10, 32'h0101_0202, 8'd62, 1'b0, 2'd3, 3'd3, 3'd3), "R9 imm repeat wrap");
    run(mk(2'b01, 32'd77, 8'd12, 1'b0, 2'd2, 3'd3, 3'd3), "R9 const fixed");
    run(mk(2'b00, 32'hC00 | 32'd9, 8'd50, 1'b0, 2'd3, 3'd3, 3'd3), "R9 rel const repeat");
    run(mk(2'b00, 32'h800 | 32'd7, 8'd2, 1'b1, 2'd3, 3'd3, 3'd3), "R9 rel both repeat");
    run(mk(2'b00, 32'd20, 8'd21, 1'b0, 2'd3, 3'd3, 3'd3), "R9 overlap propagate");
    run(mk(2'b00, 32'd20, 8'd25, 1'b0, 2'd1, 3'd3, 3'd4), "R9 R11 narrow repeat");

    // R1: rejected words
    reject(mk(2'b10, 32'h1111_1111, 8'd1, 1'b0, 2'd0, 3'd3, 3'd3) | (64'd1 << 42));
    reject(mk(2'b10, 32'h2222_2222, 8'd1, 1'b0, 2'd0, 3'd3, 3'd3) | (64'd1 << 57));
    reject((mk(2'b10, 32'h3333_3333, 8'd1, 1'b0, 2'd0, 3'd3, 3'd3) & ~(64'h7 << 61)) | (64'h2 << 61));
    reject(mk(2'b11, 32'h4444_4444, 8'hF4, 1'b0, 2'd0, 3'd4, 3'd4));
    run(mk(2'b00, 32'd1, 8'd45, 1'b0, 2'd0, 3'd3, 3'd3), "R1 reg 1 untouched");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule